// File: doc/BRIEF.md
# Fixed-Function Event Counters with Global Control

This block holds three 48-bit event counters, each tied to one event: instructions retired, core clock cycles while not halted, and reference clock cycles while not halted. A counter only counts when its own field in a shared control register allows it. The field selects the privilege level, can add events from the sibling thread, and can allow an interrupt on overflow. Software can preload each counter. A preloaded counter wraps after a chosen number of events, and that wrap is the basis for sampling.

A global group of registers covers these three counters and four general-purpose counter slices that sit outside the block. The group has three registers. The enable register starts or stops every counter in one write. The overflow status register keeps a sticky record of which counters have wrapped. The acknowledge register clears status bits when a one is written to them. A simple register port reads and writes these registers by address. The read data is combinational. A level-sensitive interrupt output stays high while any overflow with its interrupt enabled is still waiting to be acknowledged.

Top module: `perf_fixed_ctr_unit`

## Requirements
- R1: After reset, all counters, the control register, the enable register and the status register read zero, `gp_en_o` is zero and `irq_o` is low.
- R2: Fixed counter i (i = 0 to 2) has a count register at address 0x309+i. It advances by one on a clock edge when enable bit 32+i is set and either of these holds. First, `ev_own_i[i]` is high and the current privilege is allowed: control bit 4i+0 when `priv_kernel_i` is 1, control bit 4i+1 when it is 0. Second, `ev_sib_i[i]` is high and control bit 4i+2 is set. The new value is visible from the following cycle.
- R3: A counter that holds all ones and advances wraps to zero, and that same edge sets status bit 32+i.
- R4: A write to address 0x309+i loads `reg_wdata_i[47:0]` into counter i. In that cycle the write takes priority over counting, so the counter neither increments nor overflows.
- R5: The fixed control register at 0x38D holds bits 11:0 and reads them back. Field i is in bits 4i+3..4i. Bits above 11 read as zero.
- R6: The enable register at 0x38F stores bits 3:0 (general-purpose slices) and bits 34:32 (fixed counters 0 to 2). All other bits read as zero. `gp_en_o` shows bits 3:0.
- R7: The status register at 0x38E has the same bit layout as the enable register. A pulse on `gp_ovf_i[k]` sets bit k. Status bits stay set until acknowledged, and writes to 0x38E are ignored.
- R8: Writing a one to a mapped bit of 0x390 clears that status bit. An overflow in the same cycle as its own acknowledge leaves the bit set. Address 0x390 reads as zero.
- R9: `irq_o` is high exactly while a status bit is set and that bit's interrupt enable is set. For a fixed counter the enable is control bit 4i+3; for slice k it is `gp_ie_i[k]`. The output follows in the same cycle as the status or enable change.
- R10: Any other address reads zero and a write to it changes no state. This includes the slice addresses 0xC1 and up and 0x186 and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_own_i | input | 3 | Per-cycle events of this thread: [0] instruction retired, [1] unhalted core cycle, [2] unhalted reference cycle |
| ev_sib_i | input | 3 | The same events from the sibling thread |
| priv_kernel_i | input | 1 | 1 when the current thread runs in kernel mode |
| gp_ovf_i | input | 4 | Overflow pulses from the general-purpose slices |
| gp_ie_i | input | 4 | Interrupt enables of the general-purpose slices |
| gp_en_o | output | 4 | Global enable bits for the general-purpose slices |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register address for read and write |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Level-sensitive overflow interrupt |

## Verification
Directed sequences cover each counting condition on its own. Kernel-only, user-only and sibling-thread fields are run against both privilege values, which separates a wrong field bit from a wrong privilege polarity. Counters are preloaded just below all ones so that wraps happen often. An acknowledge is timed onto the exact overflow edge, which separates set-wins from clear-wins priority. A long random phase mixes every mapped and unmapped address with event bursts and slice overflow pulses. A behavioural model checks read data, interrupt and enables on every cycle, so decode aliasing and stale interrupt levels both show up.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NUM_FIXED = 3;
  localparam int FIELD_W   = 4;
  localparam int FIX_LSB   = 32;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 12;

  localparam logic [ADDR_W-1:0] ADDR_FIX0   = 12'h309;
  localparam logic [ADDR_W-1:0] ADDR_FIXCTL = 12'h38D;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 12'h38E;
  localparam logic [ADDR_W-1:0] ADDR_GEN    = 12'h38F;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 12'h390;

  // bit positions inside one control field
  localparam int F_KERN = 0;
  localparam int F_USER = 1;
  localparam int F_ANY  = 2;
  localparam int F_PMI  = 3;
endpackage

// File: rtl/pfc_fixed_ctr.sv
module pfc_fixed_ctr
  import pfc_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] ctl_i,
  input  logic               priv_kernel_i,
  input  logic               own_ev_i,
  input  logic               sib_ev_i,
  input  logic               glb_en_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit, step;

  always_comb begin
    hit   = (own_ev_i && (priv_kernel_i ? ctl_i[F_KERN] : ctl_i[F_USER]))
          || (sib_ev_i && ctl_i[F_ANY]);
    step  = glb_en_i && hit && !wr_i;
    ovf_o = step && (&cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !glb_en_i) |=> $stable(cnt_q));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/pfc_global_regs.sv
module pfc_global_regs
  import pfc_pkg::*;
#(
  parameter int NUM_GP = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_wr_i,
  input  logic                 ack_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_GP-1:0]    gp_ovf_i,
  input  logic [NUM_GP-1:0]    gp_ie_i,
  input  logic [NUM_FIXED-1:0] fix_ovf_i,
  input  logic [NUM_FIXED-1:0] fix_ie_i,
  output logic [DATA_W-1:0]    en_o,
  output logic [DATA_W-1:0]    stat_o,
  output logic                 irq_o
);
  localparam logic [DATA_W-1:0] GP_MASK  = (DATA_W'(1) << NUM_GP) - 1'b1;
  localparam logic [DATA_W-1:0] FIX_MASK = ((DATA_W'(1) << NUM_FIXED) - 1'b1) << FIX_LSB;
  localparam logic [DATA_W-1:0] MASK     = GP_MASK | FIX_MASK;

  logic [DATA_W-1:0] en_q, stat_q, set_vec, ie_vec, ack_mask;

  always_comb begin
    set_vec = '0;
    ie_vec  = '0;
    set_vec[NUM_GP-1:0]            = gp_ovf_i;
    set_vec[FIX_LSB +: NUM_FIXED]  = fix_ovf_i;
    ie_vec[NUM_GP-1:0]             = gp_ie_i;
    ie_vec[FIX_LSB +: NUM_FIXED]   = fix_ie_i;
    ack_mask = ack_wr_i ? (wdata_i & MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i & MASK;
      stat_q <= (stat_q & ~ack_mask) | set_vec;  // set beats clear
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ie_vec);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & $past(stat_q & ~ack_mask)) == $past(stat_q & ~ack_mask)));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((|$past(set_vec)) || !$stable(ie_vec)));
endmodule

// File: rtl/perf_fixed_ctr_unit.sv
module perf_fixed_ctr_unit
  import pfc_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int NUM_GP = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FIXED-1:0] ev_own_i,
  input  logic [NUM_FIXED-1:0] ev_sib_i,
  input  logic                 priv_kernel_i,
  input  logic [NUM_GP-1:0]    gp_ovf_i,
  input  logic [NUM_GP-1:0]    gp_ie_i,
  output logic [NUM_GP-1:0]    gp_en_o,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  localparam int CTL_W = NUM_FIXED * FIELD_W;

  logic [CTL_W-1:0]     ctl_q;
  logic [DATA_W-1:0]    glb_en, glb_st;
  logic [CNT_W-1:0]     fix_cnt [NUM_FIXED];
  logic [NUM_FIXED-1:0] fix_wr, fix_ovf, fix_ie;
  logic                 ctl_wr, en_wr, ack_wr, addr_hit;

  always_comb begin
    for (int i = 0; i < NUM_FIXED; i++)
      fix_wr[i] = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_FIX0 + i));
    ctl_wr = reg_we_i && (reg_addr_i == ADDR_FIXCTL);
    en_wr  = reg_we_i && (reg_addr_i == ADDR_GEN);
    ack_wr = reg_we_i && (reg_addr_i == ADDR_ACK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_wr) ctl_q <= reg_wdata_i[CTL_W-1:0];
  end

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fix
    assign fix_ie[g] = ctl_q[g*FIELD_W + F_PMI];
    pfc_fixed_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctl_i        (ctl_q[g*FIELD_W +: FIELD_W]),
      .priv_kernel_i(priv_kernel_i),
      .own_ev_i     (ev_own_i[g]),
      .sib_ev_i     (ev_sib_i[g]),
      .glb_en_i     (glb_en[FIX_LSB + g]),
      .wr_i         (fix_wr[g]),
      .wdata_i      (reg_wdata_i[CNT_W-1:0]),
      .cnt_o        (fix_cnt[g]),
      .ovf_o        (fix_ovf[g])
    );
  end

  pfc_global_regs #(.NUM_GP(NUM_GP)) i_glb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (en_wr),
    .ack_wr_i (ack_wr),
    .wdata_i  (reg_wdata_i),
    .gp_ovf_i (gp_ovf_i),
    .gp_ie_i  (gp_ie_i),
    .fix_ovf_i(fix_ovf),
    .fix_ie_i (fix_ie),
    .en_o     (glb_en),
    .stat_o   (glb_st),
    .irq_o    (irq_o)
  );

  assign gp_en_o = glb_en[NUM_GP-1:0];

  always_comb begin
    reg_rdata_o = '0;
    addr_hit    = 1'b0;
    for (int i = 0; i < NUM_FIXED; i++)
      if (reg_addr_i == ADDR_W'(ADDR_FIX0 + i)) begin
        reg_rdata_o = DATA_W'(fix_cnt[i]);
        addr_hit    = 1'b1;
      end
    case (reg_addr_i)
      ADDR_FIXCTL: begin reg_rdata_o = DATA_W'(ctl_q); addr_hit = 1'b1; end
      ADDR_STAT:   begin reg_rdata_o = glb_st;         addr_hit = 1'b1; end
      ADDR_GEN:    begin reg_rdata_o = glb_en;         addr_hit = 1'b1; end
      ADDR_ACK:    addr_hit = 1'b1;
      default: ;
    endcase
  end

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !addr_hit) |=> ($stable(ctl_q) && $stable(glb_en)));
  p_ctl_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> ctl_q == $past(reg_wdata_i[CTL_W-1:0]));
endmodule

// File: tb/test_perf_fixed_ctr_unit.sv
module test_perf_fixed_ctr_unit;
  localparam time CYC = 20ns;
  localparam logic [47:0] MAX48 = '1;
  localparam logic [63:0] GMASK = 64'h0000_0007_0000_000F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  ev_own = '0, ev_sib = '0;
  logic        priv = 1'b0;
  logic [3:0]  gp_ovf = '0, gp_ie = '0, gp_en;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  perf_fixed_ctr_unit i_perf_fixed_ctr_unit (
    .clk_i(clk), .rst_ni(rst_n), .ev_own_i(ev_own), .ev_sib_i(ev_sib),
    .priv_kernel_i(priv), .gp_ovf_i(gp_ovf), .gp_ie_i(gp_ie), .gp_en_o(gp_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  // behavioural reference
  logic [47:0] m_cnt [3];
  logic [11:0] m_ctl;
  logic [63:0] m_en, m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_cnt[i] = '0;
      m_ctl = '0; m_en = '0; m_st = '0;
    end else begin
      logic [63:0] setv, ack;
      setv = {60'd0, gp_ovf};
      for (int i = 0; i < 3; i++) begin
        bit ok;
        ok = (ev_own[i] && (priv ? m_ctl[4*i] : m_ctl[4*i+1])) || (ev_sib[i] && m_ctl[4*i+2]);
        if (we && addr == 12'h309 + i) m_cnt[i] = wdata[47:0];
        else if (ok && m_en[32+i]) begin
          if (m_cnt[i] == MAX48) begin m_cnt[i] = '0; setv[32+i] = 1'b1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      ack  = (we && addr == 12'h390) ? (wdata & GMASK) : '0;
      m_st = (m_st & ~ack) | setv;
      if (we && addr == 12'h38D) m_ctl = wdata[11:0];
      if (we && addr == 12'h38F) m_en = wdata & GMASK;
    end
  end

  function automatic logic [63:0] m_read(logic [11:0] a);
    case (a)
      12'h309: return {16'd0, m_cnt[0]};
      12'h30A: return {16'd0, m_cnt[1]};
      12'h30B: return {16'd0, m_cnt[2]};
      12'h38D: return {52'd0, m_ctl};
      12'h38E: return m_st;
      12'h38F: return m_en;
      default: return '0;
    endcase
  endfunction

  function automatic logic m_irq();
    logic [63:0] ie;
    ie = {29'd0, m_ctl[11], m_ctl[7], m_ctl[3], 28'd0, gp_ie};
    return |(m_st & ie);
  endfunction

  function automatic string req_of(logic [11:0] a);
    case (a)
      12'h309, 12'h30A, 12'h30B: return "R2";
      12'h38D: return "R5";
      12'h38E: return "R7";
      12'h38F: return "R6";
      12'h390: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk(req_of(addr), rdata, m_read(addr));
      chk("R9", 64'(irq), 64'(m_irq()));
      chk("R6", 64'(gp_en), 64'(m_en[3:0]));
    end
    we = 1'b0; ev_own = '0; ev_sib = '0; gp_ovf = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic peek(logic [11:0] a, string req, logic [63:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(12'h309, "R1", 0); peek(12'h30A, "R1", 0); peek(12'h30B, "R1", 0);
    peek(12'h38D, "R1", 0); peek(12'h38E, "R1", 0); peek(12'h38F, "R1", 0);
    chk("R1", 64'(irq), 0); chk("R1", 64'(gp_en), 0);
    step();
    // R5: fld0 kernel+pmi, fld1 user, fld2 any-thread
    wr(12'h38D, 64'hFFFF_0000_0000_0429);
    peek(12'h38D, "R5", 64'h429);
    wr(12'h38F, '1);
    peek(12'h38F, "R6", GMASK); chk("R6", 64'(gp_en), 64'hF);
    wr(12'h309, 64'hABCD_FFFF_FFFF_FFFE);
    peek(12'h309, "R4", 64'h0000_FFFF_FFFF_FFFE);
    priv = 1'b1; ev_own = 3'b011; step();
    priv = 1'b1; ev_own = 3'b011; step();
    peek(12'h309, "R3", 0);
    peek(12'h38E, "R3", 64'h1_0000_0000);
    peek(12'h30A, "R2", 0);  // user-only field, kernel mode
    chk("R9", 64'(irq), 1);
    priv = 1'b0; ev_own = 3'b010; ev_sib = 3'b100; step();
    peek(12'h30A, "R2", 1); peek(12'h30B, "R2", 1);
    wr(12'h390, 64'h1_0000_0000);
    peek(12'h38E, "R8", 0); peek(12'h390, "R8", 0);
    chk("R9", 64'(irq), 0);
    // overflow on the same edge as its acknowledge
    wr(12'h309, {16'd0, MAX48});
    priv = 1'b1; ev_own = 3'b001; we = 1'b1; addr = 12'h390; wdata = 64'h1_0000_0000; step();
    peek(12'h38E, "R8", 64'h1_0000_0000);
    wr(12'h38E, 64'h0);
    peek(12'h38E, "R7", 64'h1_0000_0000);
    gp_ovf = 4'b0100; step();
    peek(12'h38E, "R7", 64'h1_0000_0004);
    // write to counter at the overflow edge: load wins, no overflow
    wr(12'h390, '1);
    wr(12'h309, {16'd0, MAX48});
    priv = 1'b1; ev_own = 3'b001; we = 1'b1; addr = 12'h309; wdata = 64'h55; step();
    peek(12'h309, "R4", 64'h55); peek(12'h38E, "R4", 0);
    // unmapped addresses
    wr(12'h0C1, '1); wr(12'h186, '1); wr(12'h123, '1);
    peek(12'h0C1, "R10", 0); peek(12'h186, "R10", 0);
    peek(12'h38D, "R10", 64'h429); peek(12'h38F, "R10", GMASK);
    step();
    // random phase
    for (int n = 0; n < 5000; n++) begin
      logic [11:0] alist [12];
      alist = '{12'h309, 12'h30A, 12'h30B, 12'h38D, 12'h38E, 12'h38F,
                12'h390, 12'h0C1, 12'h0C3, 12'h186, 12'h188, 12'h2AA};
      ev_own = 3'($urandom); ev_sib = 3'($urandom); priv = 1'($urandom);
      gp_ovf = ($urandom % 16 == 0) ? 4'($urandom) : '0;
      if ($urandom % 32 == 0) gp_ie = 4'($urandom);
      addr = alist[$urandom % 12];
      we = ($urandom % 5 == 0);
      wdata = {$urandom, $urandom};
      if (addr == 12'h38F && ($urandom % 4 != 0)) wdata = '1;
      if (addr[11:4] == 8'h30 && $urandom % 2 == 0)
        wdata = {16'd0, 44'hFFF_FFFF_FFFF, 4'($urandom)};
      step();
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule